// File: doc/BRIEF.md
# Transmit Cell Interface Receiver (cell-level handshake)

This block sits on the physical-layer side of a transmit cell bus. A cell-layer master writes cells into it over a 16-bit data bus. The master marks the first word of each cell with a start flag and qualifies every word with an active-low write enable. Each cell is 54 bytes long, which is 27 bus words, indexed 0 to 26. The block keeps complete cells in a four-slot buffer. A downstream consumer drains them one word at a time through a valid/ready port, and an end-of-cell marker flags the last word of each cell.

Flow control works on whole cells. The block raises its available flag only when there is room for one more full cell beyond the one being written now. If the flag falls while a cell is in flight, that cell still completes, but the master must not begin another one. Cells that break the protocol are dropped and reported by a one-cycle error pulse. These are a start flag seen while the flag is low, a start flag that cuts a cell short, and a word that has no cell to belong to. Only single-device operation is built. A mode input asking for multi-device operation leaves the block inert.

Top module: `utx_cell_sink`

## Requirements
- R1: A word is taken only on a rising clock edge where `tx_en_n` is 0. With `tx_en_n` at 1, data and start-flag activity store nothing and raise no error.
- R2: A cell is 27 words, and `tx_soc` is 1 with word 0. The cell becomes readable (`cell_rd_valid` = 1) right after the edge that takes word 26. Its words come out in the order they were written.
- R3: `cell_rd_valid` is 1 while at least one complete cell is stored. A word is consumed on an edge with valid and ready both 1. `cell_rd_eoc` is 1 exactly on word 26. With ready at 0, the data holds.
- R4: The buffer holds 4 cells. `tx_cell_avail` is 1 only when the stored cells plus the cell being written number fewer than 4.
- R5: If `tx_cell_avail` falls partway through a cell, every remaining word of that cell is still taken, and the cell is stored.
- R6: A start flag taken while `tx_cell_avail` is 0 gives one `tx_err` pulse. That cell's 27 words are dropped, along with any partial cell. The dropped words that follow raise no further error.
- R7: A start flag taken before word 26 of the current cell gives one `tx_err` pulse. It discards the partial cell and begins a new cell at word 0.
- R8: A word taken with no cell in progress and `tx_soc` at 0 is ignored and gives one `tx_err` pulse.
- R9: With `cfg_multi_phy` at 1, `tx_cell_avail` stays 0, writes are ignored and no error is raised.
- R10: Synchronous active-high `rst` empties the buffer. `tx_cell_avail` reads 0 after every reset edge and rises after the first edge with `rst` at 0.
- R11: `tx_err` is 1 in the cycle right after the edge that takes the offending word, and only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_multi_phy | input | 1 | Mode bit: 0 selects single-device operation, 1 (unsupported) makes the block inert |
| tx_data | input | 16 | Write data word |
| tx_soc | input | 1 | Start flag, high with word 0 |
| tx_en_n | input | 1 | Write enable, active low |
| tx_cell_avail | output | 1 | Room for one more full cell |
| tx_err | output | 1 | One-cycle protocol error pulse |
| cell_rd_valid | output | 1 | Read word valid |
| cell_rd_ready | input | 1 | Consumer accepts the read word |
| cell_rd_data | output | 16 | Read data word |
| cell_rd_eoc | output | 1 | Read word is word 26 of its cell |

## Verification
Every result has a fixed latency. The error pulse and a newly completed cell both appear one cycle after the edge that took the deciding word. The available flag follows, in that same cycle, the edge that starts, finishes or drains a cell. Read data follows the head pointer combinationally. The bench drives inputs on falling edges and advances a behavioural queue model by one step per rising edge. On the next falling edge it compares every output against that model, so each result is checked in the exact cycle it is due, not just at some later point.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_TAKE = 2'd1,
    WS_DROP = 2'd2
  } wstate_e;

  // Room remains for one more whole cell when committed cells plus the
  // cell in flight stay below the slot count.
  function automatic logic room_for_cell(input int stored, input int busy, input int slots);
    return (stored + busy) < slots;
  endfunction

  // Slot pointer advance with wrap at the slot count.
  function automatic int next_slot(input int slot, input int slots);
    return (slot == slots - 1) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/utx_wr_ctrl.sv
module utx_wr_ctrl
  import utx_pkg::*;
#(
  parameter int CELL_WORDS = 27,
  parameter int WIDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              soc,
  input  logic              room,
  output logic              we,
  output logic [WIDX_W-1:0] widx,
  output logic              busy,
  output logic              ev_commit,
  output logic              ev_violation,
  output logic              ev_early,
  output logic              ev_stray,
  output logic              err_q
);

  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(CELL_WORDS - 1);

  wstate_e           state_q, state_n;
  logic [WIDX_W-1:0] cnt_q, cnt_n;

  always_comb begin
    state_n      = state_q;
    cnt_n        = cnt_q;
    we           = 1'b0;
    widx         = cnt_q;
    ev_commit    = 1'b0;
    ev_violation = 1'b0;
    ev_early     = 1'b0;
    ev_stray     = 1'b0;
    if (take) begin
      if (soc) begin
        if (!room) begin
          ev_violation = 1'b1;
          state_n      = WS_DROP;
          cnt_n        = WIDX_W'(1);
        end else begin
          ev_early = (state_q == WS_TAKE);
          we       = 1'b1;
          widx     = '0;
          state_n  = WS_TAKE;
          cnt_n    = WIDX_W'(1);
        end
      end else begin
        unique case (state_q)
          WS_IDLE: ev_stray = 1'b1;
          WS_TAKE: begin
            we = 1'b1;
            if (cnt_q == LAST) begin
              ev_commit = 1'b1;
              state_n   = WS_IDLE;
              cnt_n     = '0;
            end else begin
              cnt_n = cnt_q + WIDX_W'(1);
            end
          end
          WS_DROP: begin
            if (cnt_q == LAST) begin
              state_n = WS_IDLE;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_q + WIDX_W'(1);
            end
          end
          default: state_n = WS_IDLE;
        endcase
      end
    end
  end

  assign busy = (state_q == WS_TAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      err_q   <= ev_violation | ev_early | ev_stray;
    end
  end

endmodule

// File: rtl/utx_cell_store.sv
module utx_cell_store
  import utx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CELL_WORDS = 27,
  parameter int CELL_SLOTS = 4,
  parameter int WIDX_W     = 5,
  parameter int SLOT_W     = 2,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eoc,
  output logic              ev_release,
  output logic [CNT_W-1:0]  stored
);

  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(CELL_WORDS - 1);

  logic [SLOT_W-1:0] wslot_q, rslot_q;
  logic [WIDX_W-1:0] ridx_q;
  logic [CNT_W-1:0]  stored_q;
  logic [DATA_W-1:0] bank_out [CELL_SLOTS];
  logic              pop;

  for (genvar g = 0; g < CELL_SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] bank [CELL_WORDS];
    always_ff @(posedge clk) begin
      if (we && (wslot_q == SLOT_W'(g))) bank[widx] <= wdata;
    end
    assign bank_out[g] = bank[ridx_q];
  end

  assign rd_valid   = (stored_q != '0);
  assign rd_data    = bank_out[rslot_q];
  assign rd_eoc     = rd_valid && (ridx_q == LAST);
  assign pop        = rd_valid && rd_ready;
  assign ev_release = pop && (ridx_q == LAST);
  assign stored     = stored_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wslot_q  <= '0;
      rslot_q  <= '0;
      ridx_q   <= '0;
      stored_q <= '0;
    end else begin
      if (commit) wslot_q <= SLOT_W'(next_slot(int'(wslot_q), CELL_SLOTS));
      if (pop) begin
        if (ridx_q == LAST) begin
          ridx_q  <= '0;
          rslot_q <= SLOT_W'(next_slot(int'(rslot_q), CELL_SLOTS));
        end else begin
          ridx_q <= ridx_q + WIDX_W'(1);
        end
      end
      unique case ({commit, ev_release})
        2'b10:   stored_q <= stored_q + CNT_W'(1);
        2'b01:   stored_q <= stored_q - CNT_W'(1);
        default: stored_q <= stored_q;
      endcase
    end
  end

endmodule

// File: rtl/utx_room_flag.sv
module utx_room_flag
  import utx_pkg::*;
#(
  parameter int CELL_SLOTS = 4,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             multi,
  input  logic [CNT_W-1:0] stored,
  input  logic             busy,
  output logic             avail
);

  logic live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assign avail = live_q && !multi &&
                 room_for_cell(int'(stored), int'(busy), CELL_SLOTS);

endmodule

// File: rtl/utx_cell_sink.sv
module utx_cell_sink #(
  parameter int DATA_W     = 16,
  parameter int CELL_WORDS = 27,
  parameter int CELL_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_multi_phy,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_soc,
  input  logic              tx_en_n,
  output logic              tx_cell_avail,
  output logic              tx_err,
  output logic              cell_rd_valid,
  input  logic              cell_rd_ready,
  output logic [DATA_W-1:0] cell_rd_data,
  output logic              cell_rd_eoc
);

  localparam int WIDX_W = $clog2(CELL_WORDS);
  localparam int SLOT_W = (CELL_SLOTS > 1) ? $clog2(CELL_SLOTS) : 1;
  localparam int CNT_W  = $clog2(CELL_SLOTS + 1);

  logic              take;
  logic              wr_we;
  logic [WIDX_W-1:0] wr_idx;
  logic              wr_busy;
  logic              ev_commit, ev_violation, ev_early, ev_stray, ev_release;
  logic [CNT_W-1:0]  stored_cnt;

  assign take = !tx_en_n && !cfg_multi_phy;

  utx_wr_ctrl #(
    .CELL_WORDS (CELL_WORDS),
    .WIDX_W     (WIDX_W)
  ) wr_ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .soc          (tx_soc),
    .room         (tx_cell_avail),
    .we           (wr_we),
    .widx         (wr_idx),
    .busy         (wr_busy),
    .ev_commit    (ev_commit),
    .ev_violation (ev_violation),
    .ev_early     (ev_early),
    .ev_stray     (ev_stray),
    .err_q        (tx_err)
  );

  utx_cell_store #(
    .DATA_W     (DATA_W),
    .CELL_WORDS (CELL_WORDS),
    .CELL_SLOTS (CELL_SLOTS),
    .WIDX_W     (WIDX_W),
    .SLOT_W     (SLOT_W),
    .CNT_W      (CNT_W)
  ) store_i (
    .clk        (clk),
    .rst        (rst),
    .we         (wr_we),
    .widx       (wr_idx),
    .wdata      (tx_data),
    .commit     (ev_commit),
    .rd_ready   (cell_rd_ready),
    .rd_valid   (cell_rd_valid),
    .rd_data    (cell_rd_data),
    .rd_eoc     (cell_rd_eoc),
    .ev_release (ev_release),
    .stored     (stored_cnt)
  );

  utx_room_flag #(
    .CELL_SLOTS (CELL_SLOTS),
    .CNT_W      (CNT_W)
  ) room_i (
    .clk    (clk),
    .rst    (rst),
    .multi  (cfg_multi_phy),
    .stored (stored_cnt),
    .busy   (wr_busy),
    .avail  (tx_cell_avail)
  );

endmodule

// File: rtl/utx_cell_sink_chk.sv
module utx_cell_sink_chk #(
  parameter int DATA_W     = 16,
  parameter int CELL_SLOTS = 4,
  parameter int CNT_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_multi_phy,
  input logic              tx_cell_avail,
  input logic              tx_err,
  input logic              cell_rd_valid,
  input logic              cell_rd_ready,
  input logic [DATA_W-1:0] cell_rd_data,
  input logic              cell_rd_eoc,
  input logic              wr_we,
  input logic              ev_commit,
  input logic              ev_violation,
  input logic              ev_early,
  input logic              ev_stray,
  input logic              ev_release,
  input logic [CNT_W-1:0]  stored_cnt
);

  p_commit_visible_r2: assert property (@(posedge clk) disable iff (rst)
    ev_commit |=> cell_rd_valid);

  p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
    (cell_rd_valid && !cell_rd_ready) |=> (cell_rd_valid && $stable(cell_rd_data)));

  p_eoc_valid_r3: assert property (@(posedge clk) disable iff (rst)
    cell_rd_eoc |-> cell_rd_valid);

  p_release_on_eoc_r3: assert property (@(posedge clk) disable iff (rst)
    ev_release |-> cell_rd_eoc);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    ev_commit |-> (int'(stored_cnt) < CELL_SLOTS));

  p_violation_err_r6: assert property (@(posedge clk) disable iff (rst)
    ev_violation |=> tx_err);

  p_violation_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    ev_violation |-> !wr_we);

  p_early_err_r7: assert property (@(posedge clk) disable iff (rst)
    ev_early |=> tx_err);

  p_stray_err_r8: assert property (@(posedge clk) disable iff (rst)
    ev_stray |=> tx_err);

  p_multi_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_multi_phy |-> (!tx_cell_avail && !wr_we));

  p_reset_low_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tx_cell_avail);

  p_err_has_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_err) |-> $past(ev_violation || ev_early || ev_stray));

endmodule

bind utx_cell_sink utx_cell_sink_chk #(
  .DATA_W     (DATA_W),
  .CELL_SLOTS (CELL_SLOTS),
  .CNT_W      (CNT_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cfg_multi_phy (cfg_multi_phy),
  .tx_cell_avail (tx_cell_avail),
  .tx_err        (tx_err),
  .cell_rd_valid (cell_rd_valid),
  .cell_rd_ready (cell_rd_ready),
  .cell_rd_data  (cell_rd_data),
  .cell_rd_eoc   (cell_rd_eoc),
  .wr_we         (wr_we),
  .ev_commit     (ev_commit),
  .ev_violation  (ev_violation),
  .ev_early      (ev_early),
  .ev_stray      (ev_stray),
  .ev_release    (ev_release),
  .stored_cnt    (stored_cnt)
);

// File: tb/utx_cell_sink_tb_top.sv
`timescale 1ns/1ps
module utx_cell_sink_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_multi_phy = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_soc = 1'b0;
  logic        tx_en_n = 1'b1;
  logic        tx_cell_avail, tx_err, cell_rd_valid, cell_rd_eoc;
  logic        cell_rd_ready = 1'b0;
  logic [15:0] cell_rd_data;

  always #10 clk = ~clk;

  utx_cell_sink dut_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_multi_phy (cfg_multi_phy),
    .tx_data       (tx_data),
    .tx_soc        (tx_soc),
    .tx_en_n       (tx_en_n),
    .tx_cell_avail (tx_cell_avail),
    .tx_err        (tx_err),
    .cell_rd_valid (cell_rd_valid),
    .cell_rd_ready (cell_rd_ready),
    .cell_rd_data  (cell_rd_data),
    .cell_rd_eoc   (cell_rd_eoc)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  // Behavioural model state.
  logic [15:0] mq[$];
  logic [15:0] cur[$];
  int m_cells = 0, m_ridx = 0, m_state = 0, m_cnt = 0;
  bit m_err = 1'b0, m_live = 1'b0;

  function automatic bit m_avail();
    return m_live && !cfg_multi_phy && ((m_cells + ((m_state == 1) ? 1 : 0)) < 4);
  endfunction

  task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit pre_avail;
    bit pre_valid;
    bit e;
    pre_avail = m_avail();
    pre_valid = (m_cells > 0);
    if (rst) begin
      mq.delete(); cur.delete();
      m_cells = 0; m_ridx = 0; m_state = 0; m_cnt = 0;
      m_err = 1'b0; m_live = 1'b0;
      return;
    end
    m_live = 1'b1;
    e = 1'b0;
    if (pre_valid && cell_rd_ready) begin
      void'(mq.pop_front());
      if (m_ridx == 26) begin m_ridx = 0; m_cells--; end
      else m_ridx++;
    end
    if (!tx_en_n && !cfg_multi_phy) begin
      if (tx_soc) begin
        if (!pre_avail) begin
          e = 1'b1; cur.delete(); m_state = 2; m_cnt = 1;
        end else begin
          if (m_state == 1) e = 1'b1;
          cur.delete(); cur.push_back(tx_data); m_state = 1; m_cnt = 1;
        end
      end else if (m_state == 0) begin
        e = 1'b1;
      end else if (m_state == 1) begin
        cur.push_back(tx_data); m_cnt++;
        if (m_cnt == 27) begin
          foreach (cur[k]) mq.push_back(cur[k]);
          cur.delete(); m_cells++; m_state = 0; m_cnt = 0;
        end
      end else begin
        m_cnt++;
        if (m_cnt == 27) begin m_state = 0; m_cnt = 0; end
      end
    end
    m_err = e;
  endtask

  task automatic compare();
    chk(cur_req, tx_cell_avail === m_avail(), "avail", int'(tx_cell_avail), int'(m_avail()));
    chk(cur_req, tx_err === m_err, "err", int'(tx_err), int'(m_err));
    chk(cur_req, cell_rd_valid === (m_cells > 0), "rd_valid", int'(cell_rd_valid), int'(m_cells > 0));
    if (m_cells > 0) begin
      chk(cur_req, cell_rd_data === mq[0], "rd_data", int'(cell_rd_data), int'(mq[0]));
      chk(cur_req, cell_rd_eoc === (m_ridx == 26), "rd_eoc", int'(cell_rd_eoc), int'(m_ridx == 26));
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    tx_en_n = 1'b1; tx_soc = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send_word(input int id, input int idx, input bit soc);
    tx_en_n = 1'b0; tx_soc = soc; tx_data = 16'((id << 8) | idx);
    tick();
  endtask

  task automatic send_words(input int id, input int first, input int last);
    for (int i = first; i <= last; i++) send_word(id, i, i == 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: reset state
    cur_req = "R10";
    rst = 1'b1;
    tick(); tick();
    chk("R10", tx_cell_avail == 1'b0, "avail in reset", int'(tx_cell_avail), 0);
    rst = 1'b0;
    tick();
    chk("R10", tx_cell_avail == 1'b1, "avail after reset", int'(tx_cell_avail), 1);

    // R1: enable high stores nothing
    cur_req = "R1";
    tx_en_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tx_soc = (i % 3 == 0); tx_data = 16'(16'hA500 + i);
      tick();
    end
    chk("R1", cell_rd_valid == 1'b0 && tx_err == 1'b0, "no store", int'(cell_rd_valid), 0);

    // R2: one whole cell becomes visible after word 26
    cur_req = "R2";
    cell_rd_ready = 1'b0;
    send_words(1, 0, 25);
    chk("R2", cell_rd_valid == 1'b0, "not visible early", int'(cell_rd_valid), 0);
    send_word(1, 26, 1'b0);
    chk("R2", cell_rd_valid == 1'b1, "visible", int'(cell_rd_valid), 1);
    chk("R2", cell_rd_data == 16'h0100, "first word", int'(cell_rd_data), 16'h0100);
    idle(2);

    // R3: drain with a stalling consumer
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      cell_rd_ready = (i % 2 == 0);
      tick();
    end
    chk("R3", cell_rd_valid == 1'b0, "drained", int'(cell_rd_valid), 0);
    cell_rd_ready = 1'b0;

    // R4: three cells stored, fourth start drops the flag
    cur_req = "R4";
    send_words(2, 0, 26);
    send_words(3, 0, 26);
    send_words(4, 0, 26);
    chk("R4", tx_cell_avail == 1'b1, "room with 3", int'(tx_cell_avail), 1);
    send_word(5, 0, 1'b1);
    chk("R4", tx_cell_avail == 1'b0, "flag low mid cell", int'(tx_cell_avail), 0);

    // R5: the cell in flight still completes
    cur_req = "R5";
    send_words(5, 1, 26);
    chk("R5", tx_err == 1'b0 && tx_cell_avail == 1'b0, "completed", int'(tx_err), 0);

    // R6: start while flag low is dropped
    cur_req = "R6";
    send_word(6, 0, 1'b1);
    chk("R6", tx_err == 1'b1, "violation pulse", int'(tx_err), 1);
    send_words(6, 1, 26);
    chk("R6", tx_err == 1'b0, "no further errors", int'(tx_err), 0);
    idle(1);
    cell_rd_ready = 1'b1;
    idle(4 * 27 + 2);
    chk("R6", cell_rd_valid == 1'b0, "only four cells", int'(cell_rd_valid), 0);

    // R7: early start discards the partial cell
    cur_req = "R7";
    send_words(7, 0, 9);
    send_word(8, 0, 1'b1);
    chk("R7", tx_err == 1'b1, "early start pulse", int'(tx_err), 1);
    send_words(8, 1, 26);
    idle(30);

    // R8 and R11: stray word
    cur_req = "R8";
    tx_en_n = 1'b0; tx_soc = 1'b0; tx_data = 16'hBEEF;
    tick();
    chk("R8", tx_err == 1'b1, "stray pulse", int'(tx_err), 1);
    cur_req = "R11";
    idle(1);
    chk("R11", tx_err == 1'b0, "pulse is one cycle", int'(tx_err), 0);

    // R9: multi-device mode is inert
    cur_req = "R9";
    cfg_multi_phy = 1'b1;
    idle(1);
    chk("R9", tx_cell_avail == 1'b0, "flag low", int'(tx_cell_avail), 0);
    send_words(9, 0, 26);
    tx_en_n = 1'b0; tx_soc = 1'b0;
    tick();
    chk("R9", tx_err == 1'b0, "no error", int'(tx_err), 0);
    cfg_multi_phy = 1'b0;
    idle(2);
    chk("R9", cell_rd_valid == 1'b0, "nothing stored", int'(cell_rd_valid), 0);

    // R10: reset empties a loaded buffer
    cur_req = "R10";
    cell_rd_ready = 1'b0;
    send_words(10, 0, 26);
    rst = 1'b1;
    tick();
    chk("R10", cell_rd_valid == 1'b0 && tx_cell_avail == 1'b0, "emptied", int'(cell_rd_valid), 0);
    rst = 1'b0;
    idle(3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule